// File: doc/BRIEF.md
# SPI Serial Nonvolatile Memory Slave Controller

This block is the command side of a small serial memory that sits on an SPI bus as a slave. It holds a byte array (4096 bytes by default), decodes the instruction and address bytes a master shifts in, returns array or status data, and accepts page writes. A status register carries a busy flag, a volatile write-enable latch and two protection bits that fence off a quarter, a half or all of the array. A hardware write-protect input blocks changes to the status register.

SCK, CS_n and SI are oversampled by a fast system clock through two-stage synchronizers, so SCK must stay well below that clock (the bench uses twelve system clocks per SCK period). When a frame that stored data or the status byte ends, a busy period of `WRITE_CYCLES` system clocks follows. During that period only the status read is honoured.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: SPI modes 0 and 3 both work. SI is taken on each rising SCK edge and SO changes after each falling SCK edge. Every byte moves most significant bit first.
- R2: Opcodes are 0x06 set latch, 0x04 clear latch, 0x05 read status, 0x01 write status, 0x03 read and 0x02 write. Any other opcode makes the rest of the frame have no effect until CS_n rises.
- R3: Read and write send two address bytes, high byte first. Only the low 12 bits select a byte, so the upper 4 bits have no effect.
- R4: A read returns bytes from consecutive addresses for as long as SCK runs, and wraps from 0xFFF to 0x000.
- R5: A write stores consecutive data bytes. The low 5 address bits wrap inside the same 32-byte page.
- R6: The write-enable latch is set by 0x06. It is cleared by 0x04, by reset and by the end of any write or status-write frame that was accepted. A write or status write sent while the latch is 0 has no effect.
- R7: The status byte reads as bit0 busy, bit1 latch, bits 3:2 protection code and zeros above. Read status repeats the current status in every following byte. A status write stores only bits 3:2.
- R8: Protection code 0 protects nothing, 1 protects 0xC00-0xFFF, 2 protects 0x800-0xFFF and 3 protects everything. Bytes aimed at protected addresses are discarded.
- R9: When CS_n rises after a frame that stored at least one byte or a status byte, busy is set for `WRITE_CYCLES` clocks and then clears.
- R10: While busy, only read status acts. A latch-set has no effect and a read returns no data, with the output enable kept low.
- R11: While wp_n is low, a status write has no effect and leaves the latch unchanged.
- R12: so_oe is high only while a selected frame returns read or status data. It is low when CS_n is high.
- R13: After reset, the status reads 0x00 and so_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the master |
| wp_n | input | 1 | Active-low hardware write protect for the status register |
| so | output | 1 | Serial data to the master |
| so_oe | output | 1 | Drive enable for so (1 = drive, 0 = high impedance) |

## Verification
The self-timed busy period and a status poll can overlap: busy starts on the clock after CS_n rises, and it can end while a read-status frame is reloading its status byte. The bench provokes this by polling read status right after each write frame and then repeatedly until busy clears. It expects the first poll to show busy set with the latch cleared, and a later poll to show busy clear. A latch-set and a read are also sent inside the busy window; the bench judges them by a latch that stays 0 and an output enable that never rises.

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl #(
  parameter int ADDR_W       = 12,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [7:0] OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_RDSR = 8'h05,
                         OP_WRSR = 8'h01, OP_READ = 8'h03, OP_WRITE = 8'h02;

  typedef enum logic [2:0] {S_OPC, S_AH, S_AL, S_WD, S_RD, S_SR, S_WS, S_IGN} st_t;

  logic [2:0] sck_r, cs_r;
  logic [1:0] si_r, wp_r;
  st_t st;
  logic [2:0] cnt;
  logic [6:0] sh;
  logic [ADDR_W-9:0] ahi;
  logic [ADDR_W-1:0] ptr;
  logic [7:0] osh;
  logic rdm, wel, busy, wr_frame, wr_pend;
  logic [1:0] bp;
  logic [CNT_W-1:0] tmr;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_r <= '0;
      cs_r  <= '1;
      si_r  <= '0;
      wp_r  <= '1;
    end else begin
      sck_r <= {sck_r[1:0], sck};
      cs_r  <= {cs_r[1:0], cs_n};
      si_r  <= {si_r[0], si};
      wp_r  <= {wp_r[0], wp_n};
    end

  wire sel      = ~cs_r[1];
  wire cs_rise  = cs_r[1] & ~cs_r[2];
  wire sck_rise = sck_r[1] & ~sck_r[2];
  wire sck_fall = ~sck_r[1] & sck_r[2];
  wire [7:0] byte_in = {sh, si_r[1]};
  wire byte_done = sel & sck_rise & (cnt == 3'd7);
  wire [ADDR_W-1:0] a_new = {ahi, byte_in};
  wire [ADDR_W-1:0] ptr_inc = ptr + ADDR_W'(1);
  wire [ADDR_W-1:0] ptr_pg  = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
  wire [7:0] status = {4'b0000, bp, wel, busy};
  wire prot_hit = (bp == 2'd3) || (bp == 2'd2 && ptr[ADDR_W-1]) ||
                  (bp == 2'd1 && (&ptr[ADDR_W-1:ADDR_W-2]));
  wire wr_hit = byte_done && st == S_WD && !prot_hit;

  assign so    = osh[7];
  assign so_oe = sel && (st == S_RD || st == S_SR);

  always_ff @(posedge clk)
    if (wr_hit) mem[ptr] <= byte_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_OPC;  cnt <= '0;  sh <= '0;  ahi <= '0;  ptr <= '0;  osh <= '0;
      rdm <= 1'b0;  wel <= 1'b0;  bp <= '0;  busy <= 1'b0;  tmr <= '0;
      wr_frame <= 1'b0;  wr_pend <= 1'b0;
    end else begin
      if (busy) begin
        if (tmr == '0) busy <= 1'b0;
        else tmr <= tmr - CNT_W'(1);
      end
      if (!sel) begin
        st  <= S_OPC;
        cnt <= '0;
        if (cs_rise) begin
          if (wr_frame) wel <= 1'b0;
          if (wr_pend) begin
            busy <= 1'b1;
            tmr  <= CNT_W'(WRITE_CYCLES - 1);
          end
          wr_frame <= 1'b0;
          wr_pend  <= 1'b0;
        end
      end else begin
        if (sck_fall && cnt != 3'd0) osh <= {osh[6:0], 1'b0};
        if (sck_rise) begin
          cnt <= cnt + 3'd1;
          sh  <= {sh[5:0], si_r[1]};
        end
        if (byte_done)
          case (st)
            S_OPC:
              if (busy) begin
                st  <= (byte_in == OP_RDSR) ? S_SR : S_IGN;
                osh <= status;
              end else
                case (byte_in)
                  OP_WREN: begin wel <= 1'b1; st <= S_IGN; end
                  OP_WRDI: begin wel <= 1'b0; st <= S_IGN; end
                  OP_RDSR: begin osh <= status; st <= S_SR; end
                  OP_WRSR:
                    if (wel && wp_r[1]) begin st <= S_WS; wr_frame <= 1'b1; end
                    else st <= S_IGN;
                  OP_READ: begin rdm <= 1'b1; st <= S_AH; end
                  OP_WRITE:
                    if (wel) begin rdm <= 1'b0; wr_frame <= 1'b1; st <= S_AH; end
                    else st <= S_IGN;
                  default: st <= S_IGN;
                endcase
            S_AH: begin ahi <= byte_in[ADDR_W-9:0]; st <= S_AL; end
            S_AL: begin
              ptr <= a_new;
              if (rdm) begin osh <= mem[a_new]; st <= S_RD; end
              else st <= S_WD;
            end
            S_RD: begin ptr <= ptr_inc; osh <= mem[ptr_inc]; end
            S_WD: begin
              if (!prot_hit) wr_pend <= 1'b1;
              ptr <= ptr_pg;
            end
            S_SR: osh <= status;
            S_WS: begin bp <= byte_in[3:2]; wr_pend <= 1'b1; st <= S_IGN; end
            default: ;
          endcase
      end
    end
endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       cs_hi,
  input logic       so_oe,
  input logic       busy,
  input logic       wel,
  input logic [1:0] bp
);
  // R6
  busy_no_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wel);

  // R12
  idle_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 2) |-> !so_oe);

  // R10
  busy_bp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bp));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_hi));
endmodule

bind spi_eeprom_ctrl spi_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_hi(cs_r[1]),
  .so_oe(so_oe), .busy(busy), .wel(wel), .bp(bp)
);

// File: tb/spi_eeprom_ctrl_bench.sv
module spi_eeprom_ctrl_bench;
  localparam int WC = 1500;
  localparam int H  = 6;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe;

  always #2 clk = ~clk;

  spi_eeprom_ctrl #(.WRITE_CYCLES(WC)) u_spi_eeprom_ctrl (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [4096];
  bit kn [4096];
  logic [1:0] bp_m = 2'd0;
  bit wel_m = 1'b0;
  bit mode3 = 1'b0;
  logic [7:0] tx [64];
  logic [7:0] rx [64];
  logic [7:0] st_v;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit prot_f(logic [11:0] a, logic [1:0] b);
    return (b == 2'd3) || (b == 2'd2 && a[11]) || (b == 2'd1 && a[11:10] == 2'b11);
  endfunction

  task automatic frame(int nb, int oe_from);
    int oe_bad;
    oe_bad = 0;
    sck = mode3;
    tick(H);
    cs_n = 1'b0;
    tick(H);
    for (int b = 0; b < nb; b++) begin
      logic [7:0] r;
      r = '0;
      for (int i = 7; i >= 0; i--) begin
        sck = 1'b0;
        si  = tx[b][i];
        tick(H);
        r[i] = so;
        if (so_oe !== ((oe_from >= 0) && (b >= oe_from))) oe_bad++;
        sck = 1'b1;
        tick(H);
      end
      rx[b] = r;
    end
    if (!mode3) sck = 1'b0;
    tick(H);
    cs_n = 1'b1;
    tick(2 * H);
    chk("R12 output enable", oe_bad, 0);
  endtask

  task automatic rdsr(output logic [7:0] s);
    tx[0] = 8'h05; tx[1] = 8'h00; tx[2] = 8'h00;
    frame(3, 1);
    s = rx[2];
  endtask

  task automatic cmd(logic [7:0] op);
    tx[0] = op;
    frame(1, -1);
    if (op == 8'h06) wel_m = 1'b1;
    if (op == 8'h04) wel_m = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int polls;
    polls = 0;
    do begin
      rdsr(s);
      polls++;
    end while (s[0] && polls < 60);
    chk("R9 busy clears", s[0], 0);
  endtask

  task automatic do_write(logic [15:0] addr, int n);
    logic [11:0] a;
    tx[0] = 8'h02; tx[1] = addr[15:8]; tx[2] = addr[7:0];
    for (int i = 0; i < n; i++) tx[3 + i] = 8'($urandom);
    frame(3 + n, -1);
    if (wel_m) begin
      a = addr[11:0];
      for (int i = 0; i < n; i++) begin
        if (!prot_f(a, bp_m)) begin mdl[a] = tx[3 + i]; kn[a] = 1'b1; end
        a = {a[11:5], a[4:0] + 5'd1};
      end
      wel_m = 1'b0;
    end
  endtask

  task automatic do_read(string req, logic [15:0] addr, int n);
    logic [11:0] a;
    tx[0] = 8'h03; tx[1] = addr[15:8]; tx[2] = addr[7:0];
    for (int i = 0; i < n; i++) tx[3 + i] = 8'h00;
    frame(3 + n, 3);
    a = addr[11:0];
    for (int i = 0; i < n; i++) begin
      if (kn[a]) chk(req, rx[3 + i], mdl[a]);
      a = a + 12'd1;
    end
  endtask

  task automatic wrsr(logic [7:0] v);
    tx[0] = 8'h01; tx[1] = v;
    frame(2, -1);
    if (wel_m && wp_n) begin bp_m = v[3:2]; wel_m = 1'b0; end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 4096; i++) kn[i] = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R13 so_oe after reset", so_oe, 0);
    rdsr(st_v); chk("R13 status after reset", st_v, 8'h00);

    cmd(8'h06); rdsr(st_v); chk("R6 latch set", st_v, 8'h02);
    cmd(8'h04); rdsr(st_v); chk("R6 latch cleared", st_v, 8'h00);

    do_write(16'h0040, 2);
    rdsr(st_v); chk("R6 write without latch", st_v, 8'h00);

    cmd(8'h06);
    do_write(16'h0010, 5);
    rdsr(st_v); chk("R9 busy after write", st_v, 8'h01);
    tx[0] = 8'h06; frame(1, -1);
    rdsr(st_v); chk("R10 latch-set while busy", st_v, 8'h01);
    tx[0] = 8'h03; tx[1] = 8'h00; tx[2] = 8'h10; tx[3] = 8'h00; tx[4] = 8'h00;
    frame(5, -1);
    wait_idle();
    rdsr(st_v); chk("R9 idle status", st_v, 8'h00);
    do_read("R4 read back", 16'h0010, 5);

    mode3 = 1'b1;
    cmd(8'h06); do_write(16'h0A1E, 5); wait_idle();
    do_read("R5 page wrap", 16'h0A00, 32);
    cmd(8'h06); do_write(16'hF123, 2); wait_idle();
    do_read("R3 upper bits", 16'h0123, 2);
    mode3 = 1'b0;
    cmd(8'h06); do_write(16'h0FFE, 2); wait_idle();
    cmd(8'h06); do_write(16'h0000, 2); wait_idle();
    do_read("R4 array wrap", 16'h0FFE, 4);

    tx[0] = 8'hAB; tx[1] = 8'h06; frame(2, -1);
    rdsr(st_v); chk("R2 unknown opcode", st_v, 8'h00);

    for (int it = 0; it < 8; it++) begin
      logic [15:0] ad;
      int n;
      mode3 = 1'($urandom);
      ad = 16'($urandom);
      n = 1 + int'($urandom % 34);
      cmd(8'h06); do_write(ad, n); wait_idle();
      do_read("R1 random mode", ad, n);
    end
    mode3 = 1'b0;

    cmd(8'h06); do_write(16'h0C00, 1); wait_idle();
    cmd(8'h06); do_write(16'h0800, 1); wait_idle();
    cmd(8'h06); do_write(16'h0BFF, 1); wait_idle();
    cmd(8'h06); do_write(16'h07FF, 1); wait_idle();

    cmd(8'h06); wrsr(8'h04);
    rdsr(st_v); chk("R9 busy after status write", st_v[0], 1);
    wait_idle();
    rdsr(st_v); chk("R7 status quarter", st_v, 8'h04);
    cmd(8'h06); do_write(16'h0C00, 1);
    rdsr(st_v); chk("R8 protected write no busy", st_v, 8'h04);
    cmd(8'h06); do_write(16'h0BFF, 1); wait_idle();
    do_read("R8 quarter", 16'h0BFF, 2);

    cmd(8'h06); wrsr(8'h08); wait_idle();
    cmd(8'h06); do_write(16'h0800, 1); wait_idle();
    cmd(8'h06); do_write(16'h07FF, 1); wait_idle();
    do_read("R8 half", 16'h07FF, 2);

    cmd(8'h06); wrsr(8'hFF); wait_idle();
    rdsr(st_v); chk("R7 status mask", st_v, 8'h0C);
    cmd(8'h06); do_write(16'h0000, 2); wait_idle();
    do_read("R8 all", 16'h0000, 2);

    wp_n = 1'b0;
    tick(4);
    cmd(8'h06); wrsr(8'h00);
    rdsr(st_v); chk("R11 status write blocked", st_v, 8'h0E);
    wp_n = 1'b1;
    tick(4);
    wrsr(8'h00); wait_idle();
    rdsr(st_v); chk("R11 status write released", st_v, 8'h00);

    cmd(8'h06);
    tx[0] = 8'h02; tx[1] = 8'h00; tx[2] = 8'h00; frame(3, -1);
    wel_m = 1'b0;
    rdsr(st_v); chk("R6 empty write clears latch", st_v, 8'h00);

    finish_run();
  end
endmodule